// File: doc/BRIEF.md
# Flash Block Protection Controller

This block holds the protection state of a block-structured flash array. The state is a set of sticky protection bits, one for each group of blocks, a volatile lock-down flag that freezes those bits, two one-way mode bits (standard mode and password mode), and a 64-bit password kept as four 16-bit words. A command decoder upstream turns bus cycles into single decoded commands. This block takes those commands on a valid/ready stream, applies them, and answers each one with a one-cycle response pulse that carries an error flag. A combinational query port gives the protect state of any block, and a write-protect pin can force protection onto the outermost blocks.

There are two resets. `rst_n` is the power-on reset and loads the shipped values: nothing protected, standard mode in effect with neither mode bit set, and the password words all ones. `hw_rst` is a synchronous pulse that models the hardware reset pin. It clears only the volatile state. Lock-down then reloads as 1 in password mode and as 0 otherwise, and a verify sequence that was in progress is dropped.

Back-pressure: a command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` drops for exactly `PGM_CYCLES` cycles after each successful command that writes persistent state, which is opcodes 0, 1, 2, 5 and 6. Rejected commands and volatile commands leave it high. It is also low during `hw_rst`. The response has no ready signal and cannot be stalled.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After `rst_n`, `cmd_ready`=1, `lockdown`=0, `std_locked`=0 and `pwd_locked`=0, and every block reads unprotected while `wp_active`=0.
- R2: `qry_prot` = group bit of (`qry_blk` >> `GRP_SHIFT`) OR (`wp_active` AND the block is one of the `OUTER_BLKS` lowest or `OUTER_BLKS` highest blocks).
- R3: Opcode 5 sets the group bit `cmd_grp`, and opcode 6 clears every group bit. Both are rejected with an error, and change nothing, while `lockdown`=1. Group bits survive `hw_rst`.
- R4: Opcode 4 sets `lockdown`. No command clears it except a successful password verify (R7). `hw_rst` loads it with the value of `pwd_locked`.
- R5: Opcode 0 sets `std_locked` and fails if `pwd_locked`=1. Opcode 1 fails if `std_locked`=1 or if any of the four password words was never programmed. Otherwise it sets `pwd_locked` and `lockdown`. The two mode bits never clear except by `rst_n`.
- R6: Opcode 2 writes `cmd_data` into password word `cmd_idx` (0 to 3). It is rejected once `pwd_locked`=1.
- R7: Opcode 3 checks word `cmd_idx` against `cmd_data`. The words must arrive in index order 0,1,2,3. The step for word 3 clears `lockdown` when all four words matched, and errors with `lockdown` unchanged when any word did not. A step out of order, or any verify step outside password mode, errors and restarts the sequence, and so does any other accepted command.
- R8: `rsp_valid` pulses exactly one cycle after each accepted command, and `rsp_err` can be high only with it.
- R9: After a successful opcode 0, 1, 2, 5 or 6, `cmd_ready` is low for exactly `PGM_CYCLES` cycles. It stays high after any other accepted command, and it is low while `hw_rst`=1.
- R10: Opcode 7 is invalid. It answers with an error and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hw_rst | input | 1 | Synchronous hardware reset pulse, clears volatile state |
| wp_active | input | 1 | Write-protect pin, protects the outermost blocks when high |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_op | input | 3 | Command opcode (0 to 7) |
| cmd_grp | input | log2(NUM_BLOCKS>>GRP_SHIFT) | Group index for opcode 5 |
| cmd_idx | input | log2(PW_WORDS) | Password word index for opcodes 2 and 3 |
| cmd_data | input | WORD_W | Password word for opcodes 2 and 3 |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Command rejected or password mismatch |
| lockdown | output | 1 | Lock-down flag |
| std_locked | output | 1 | Standard-mode lock bit |
| pwd_locked | output | 1 | Password-mode lock bit |
| qry_blk | input | log2(NUM_BLOCKS) | Block index to query |
| qry_prot | output | 1 | Queried block is protected |

## Verification
The checker watches a few properties on every cycle. The two mode bits are never both set and never fall. Lock-down falls only on a verify step or a hardware reset. Every accepted command gets exactly one response one cycle later. The write-protect pin always protects the outer blocks, and ready stays low during `hw_rst` and right after a successful group set. Only the bench's scenarios can show the properties that depend on what was stored. These are whether the four password words actually match, whether an interrupted or reordered verify sequence fails, how long the busy window lasts, and whether rejected commands left the group bits and mode bits untouched.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [2:0] {
    OP_SET_STD  = 3'd0,
    OP_SET_PWD  = 3'd1,
    OP_PGM_PWD  = 3'd2,
    OP_VFY_PWD  = 3'd3,
    OP_SET_LOCK = 3'd4,
    OP_SET_GRP  = 3'd5,
    OP_CLR_ALL  = 3'd6,
    OP_INVALID  = 3'd7
  } fpc_op_e;
endpackage

// File: rtl/fpc_pwd_bank.sv
module fpc_pwd_bank #(
  parameter int PW_WORDS = 4,
  parameter int WORD_W   = 16,
  localparam int IW      = $clog2(PW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [WORD_W-1:0] data,
  output logic              match,
  output logic              all_written
);
  logic [WORD_W-1:0] word_q [PW_WORDS];
  logic [PW_WORDS-1:0] wr_q;

  // Password words start erased (all ones), marks start clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < PW_WORDS; w++) word_q[w] <= '1;
      wr_q <= '0;
    end else if (we) begin
      for (int w = 0; w < PW_WORDS; w++) begin
        if (idx == IW'(w)) begin
          word_q[w] <= data;
          wr_q[w]   <= 1'b1;
        end
      end
    end
  end

  assign match       = (word_q[idx] == data);
  assign all_written = &wr_q;
endmodule

// File: rtl/fpc_grp_bits.sv
module fpc_grp_bits #(
  parameter int NUM_BLOCKS = 32,
  parameter int GRP_SHIFT  = 1,
  parameter int OUTER_BLKS = 2,
  localparam int NUM_GRPS  = NUM_BLOCKS >> GRP_SHIFT,
  localparam int GW        = $clog2(NUM_GRPS),
  localparam int BW        = $clog2(NUM_BLOCKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [GW-1:0] set_grp,
  input  logic          clr_all,
  input  logic          wp_active,
  input  logic [BW-1:0] qry_blk,
  output logic          qry_prot
);
  logic [NUM_GRPS-1:0]   bits_q;
  logic [NUM_BLOCKS-1:0] outer;
  logic [BW-1:0]         grp_of;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (clr_all) bits_q <= '0;
    else if (set_en)  bits_q[set_grp] <= 1'b1;
  end

  // Mask of blocks covered by the write-protect pin.
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_outer
    if ((b < OUTER_BLKS) || (b >= NUM_BLOCKS - OUTER_BLKS)) begin : g_edge
      assign outer[b] = 1'b1;
    end else begin : g_mid
      assign outer[b] = 1'b0;
    end
  end

  assign grp_of   = qry_blk >> GRP_SHIFT;
  assign qry_prot = bits_q[grp_of[GW-1:0]] | (wp_active & outer[qry_blk]);
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int PW_WORDS   = 4,
  parameter int PGM_CYCLES = 5,
  localparam int IW        = $clog2(PW_WORDS),
  localparam int CW        = $clog2(PGM_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_idx,
  input  logic          pw_match,
  input  logic          pw_all_written,
  output logic          pw_we,
  output logic          grp_set,
  output logic          grp_clr,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic          lockdown,
  output logic          std_locked,
  output logic          pwd_locked
);
  localparam logic [IW-1:0] LAST_IDX = IW'(PW_WORDS - 1);

  fpc_op_e       op;
  logic          accept, err_c, nv_ok, ld_set, ld_clr, std_set, pwd_set;
  logic          vfy_adv, vfy_rst;
  logic [IW-1:0] vfy_next;
  logic          vfy_bad;
  logic [CW-1:0] busy_q;

  assign op        = fpc_op_e'(cmd_op);
  assign cmd_ready = (busy_q == '0) && !hw_rst;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    err_c   = 1'b0;
    nv_ok   = 1'b0;
    pw_we   = 1'b0;
    grp_set = 1'b0;
    grp_clr = 1'b0;
    ld_set  = 1'b0;
    ld_clr  = 1'b0;
    std_set = 1'b0;
    pwd_set = 1'b0;
    vfy_adv = 1'b0;
    vfy_rst = accept;
    if (accept) begin
      case (op)
        OP_SET_STD: begin
          if (pwd_locked) err_c = 1'b1;
          else begin std_set = 1'b1; nv_ok = 1'b1; end
        end
        OP_SET_PWD: begin
          if (std_locked || !pw_all_written) err_c = 1'b1;
          else begin pwd_set = 1'b1; ld_set = 1'b1; nv_ok = 1'b1; end
        end
        OP_PGM_PWD: begin
          if (pwd_locked) err_c = 1'b1;
          else begin pw_we = 1'b1; nv_ok = 1'b1; end
        end
        OP_VFY_PWD: begin
          if (!pwd_locked || (cmd_idx != vfy_next)) err_c = 1'b1;
          else if (cmd_idx == LAST_IDX) begin
            if (vfy_bad || !pw_match) err_c = 1'b1;
            else ld_clr = 1'b1;
          end else begin
            vfy_adv = 1'b1;
            vfy_rst = 1'b0;
          end
        end
        OP_SET_LOCK: ld_set = 1'b1;
        OP_SET_GRP: begin
          if (lockdown) err_c = 1'b1;
          else begin grp_set = 1'b1; nv_ok = 1'b1; end
        end
        OP_CLR_ALL: begin
          if (lockdown) err_c = 1'b1;
          else begin grp_clr = 1'b1; nv_ok = 1'b1; end
        end
        default: err_c = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_locked <= 1'b0;
      pwd_locked <= 1'b0;
      lockdown   <= 1'b0;
      vfy_next   <= '0;
      vfy_bad    <= 1'b0;
      busy_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
    end else if (hw_rst) begin
      lockdown  <= pwd_locked;
      vfy_next  <= '0;
      vfy_bad   <= 1'b0;
      busy_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= err_c;
      if (std_set) std_locked <= 1'b1;
      if (pwd_set) pwd_locked <= 1'b1;
      if (ld_set)      lockdown <= 1'b1;
      else if (ld_clr) lockdown <= 1'b0;
      if (vfy_adv) begin
        vfy_next <= vfy_next + 1'b1;
        vfy_bad  <= vfy_bad | !pw_match;
      end else if (vfy_rst) begin
        vfy_next <= '0;
        vfy_bad  <= 1'b0;
      end
      if (nv_ok)               busy_q <= CW'(PGM_CYCLES);
      else if (busy_q != '0)   busy_q <= busy_q - 1'b1;
    end
  end
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl #(
  parameter int NUM_BLOCKS = 32,
  parameter int GRP_SHIFT  = 1,
  parameter int OUTER_BLKS = 2,
  parameter int PW_WORDS   = 4,
  parameter int WORD_W     = 16,
  parameter int PGM_CYCLES = 5,
  localparam int NUM_GRPS  = NUM_BLOCKS >> GRP_SHIFT,
  localparam int GW        = $clog2(NUM_GRPS),
  localparam int BW        = $clog2(NUM_BLOCKS),
  localparam int IW        = $clog2(PW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst,
  input  logic              wp_active,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [GW-1:0]     cmd_grp,
  input  logic [IW-1:0]     cmd_idx,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              lockdown,
  output logic              std_locked,
  output logic              pwd_locked,
  input  logic [BW-1:0]     qry_blk,
  output logic              qry_prot
);
  logic pw_we, pw_match, pw_all_written, grp_set, grp_clr;

  fpc_seq #(.PW_WORDS(PW_WORDS), .PGM_CYCLES(PGM_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .pw_match(pw_match), .pw_all_written(pw_all_written), .pw_we(pw_we),
    .grp_set(grp_set), .grp_clr(grp_clr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .lockdown(lockdown), .std_locked(std_locked), .pwd_locked(pwd_locked)
  );

  fpc_pwd_bank #(.PW_WORDS(PW_WORDS), .WORD_W(WORD_W)) pwd_i (
    .clk(clk), .rst_n(rst_n), .we(pw_we), .idx(cmd_idx), .data(cmd_data),
    .match(pw_match), .all_written(pw_all_written)
  );

  fpc_grp_bits #(.NUM_BLOCKS(NUM_BLOCKS), .GRP_SHIFT(GRP_SHIFT), .OUTER_BLKS(OUTER_BLKS)) grp_i (
    .clk(clk), .rst_n(rst_n), .set_en(grp_set), .set_grp(cmd_grp), .clr_all(grp_clr),
    .wp_active(wp_active), .qry_blk(qry_blk), .qry_prot(qry_prot)
  );
endmodule

// File: rtl/flash_prot_ctrl_chk.sv
module flash_prot_ctrl_chk
  import fpc_pkg::*;
#(
  parameter int NUM_BLOCKS = 32,
  parameter int OUTER_BLKS = 2,
  localparam int BW        = $clog2(NUM_BLOCKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hw_rst,
  input logic          wp_active,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [2:0]    cmd_op,
  input logic [BW-1:0] qry_blk,
  input logic          qry_prot,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          lockdown,
  input logic          std_locked,
  input logic          pwd_locked
);
  logic acc, edge_blk;
  assign acc      = cmd_valid && cmd_ready;
  assign edge_blk = (int'(qry_blk) < OUTER_BLKS) || (int'(qry_blk) >= NUM_BLOCKS - OUTER_BLKS);

  AST_WP_EDGE_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_active && edge_blk) |-> qry_prot);  // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lockdown && !hw_rst && !(acc && cmd_op == OP_VFY_PWD)) |=> lockdown);  // R4
  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(std_locked && pwd_locked));  // R5
  AST_STD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    std_locked |=> std_locked);  // R5
  AST_PWD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pwd_locked |=> pwd_locked);  // R5
  AST_RSP_ONE_PER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);  // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);  // R8
  AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);  // R8
  AST_BUSY_AFTER_GRP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_SET_GRP && !lockdown) |=> !cmd_ready);  // R9
  AST_READY_LOW_HWRST: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |-> !cmd_ready);  // R9
endmodule

bind flash_prot_ctrl flash_prot_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS), .OUTER_BLKS(OUTER_BLKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .wp_active(wp_active),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .qry_blk(qry_blk), .qry_prot(qry_prot), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .lockdown(lockdown), .std_locked(std_locked), .pwd_locked(pwd_locked)
);

// File: tb/flash_prot_ctrl_tb_top.sv
module flash_prot_ctrl_tb_top;
  localparam int PGM = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_rst = 1'b0;
  logic        wp_active = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [3:0]  cmd_grp = 4'd0;
  logic [1:0]  cmd_idx = 2'd0;
  logic [15:0] cmd_data = 16'd0;
  logic        rsp_valid, rsp_err, lockdown, std_locked, pwd_locked;
  logic [4:0]  qry_blk = 5'd0;
  logic        qry_prot;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_prot_ctrl #(.PGM_CYCLES(PGM)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .wp_active(wp_active),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_grp(cmd_grp),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .lockdown(lockdown), .std_locked(std_locked), .pwd_locked(pwd_locked),
    .qry_blk(qry_blk), .qry_prot(qry_prot)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_grp [16];
  int m_pw [4];
  bit m_wr [4];
  bit m_std, m_pwd, m_ld, m_rv, m_re, m_vbad;
  int m_vn, m_busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_grp[i]) m_grp[i] = 0;
      foreach (m_pw[i]) begin m_pw[i] = 16'hFFFF; m_wr[i] = 0; end
      m_std = 0; m_pwd = 0; m_ld = 0; m_rv = 0; m_re = 0; m_vbad = 0;
      m_vn = 0; m_busy = 0;
    end else if (hw_rst) begin
      m_ld = m_pwd; m_vn = 0; m_vbad = 0; m_busy = 0; m_rv = 0; m_re = 0;
    end else begin
      bit acc, e, nv, keep;
      acc = cmd_valid && (m_busy == 0);
      e = 0; nv = 0; keep = 0;
      if (m_busy > 0) m_busy--;
      if (acc) begin
        case (int'(cmd_op))
          0: if (m_pwd) e = 1; else begin m_std = 1; nv = 1; end
          1: if (m_std || !(m_wr[0] && m_wr[1] && m_wr[2] && m_wr[3])) e = 1;
             else begin m_pwd = 1; m_ld = 1; nv = 1; end
          2: if (m_pwd) e = 1;
             else begin m_pw[cmd_idx] = int'(cmd_data); m_wr[cmd_idx] = 1; nv = 1; end
          3: if (!m_pwd || int'(cmd_idx) != m_vn) e = 1;
             else if (cmd_idx == 2'd3) begin
               if (m_vbad || m_pw[3] != int'(cmd_data)) e = 1; else m_ld = 0;
             end else begin
               if (m_pw[cmd_idx] != int'(cmd_data)) m_vbad = 1;
               m_vn++; keep = 1;
             end
          4: m_ld = 1;
          5: if (m_ld) e = 1; else begin m_grp[cmd_grp] = 1; nv = 1; end
          6: if (m_ld) e = 1; else begin foreach (m_grp[i]) m_grp[i] = 0; nv = 1; end
          default: e = 1;
        endcase
        if (!keep) begin m_vn = 0; m_vbad = 0; end
      end
      if (nv) m_busy = PGM;
      m_rv = acc; m_re = e;
    end
  end

  function automatic bit exp_prot();
    int b = int'(qry_blk);
    return m_grp[b >> 1] | (wp_active && (b < 2 || b >= 30));
  endfunction

  // Compare on every clock, 5 ns after the edge.
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check("R9 cmd_ready", int'(cmd_ready), int'(m_busy == 0 && !hw_rst));
      check("R8 rsp_valid", int'(rsp_valid), int'(m_rv));
      check("R8 rsp_err", int'(rsp_err), int'(m_re));
      check("R4 lockdown", int'(lockdown), int'(m_ld));
      check("R5 std_locked", int'(std_locked), int'(m_std));
      check("R5 pwd_locked", int'(pwd_locked), int'(m_pwd));
      check("R2 qry_prot", int'(qry_prot), int'(exp_prot()));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input int op, input int grp, input int idx, input int data, output bit err);
    @(negedge clk);
    cmd_op = 3'(op); cmd_grp = 4'(grp); cmd_idx = 2'(idx); cmd_data = 16'(data);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 response pulse", int'(rsp_valid), 1);
    err = rsp_err;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
  endtask

  task automatic prot_of(input int blk, output bit p);
    qry_blk = 5'(blk); #1; p = qry_prot;
  endtask

  task automatic pulse_hw();
    @(negedge clk); hw_rst = 1'b1;
    #1; check("R9 ready low in hw_rst", int'(cmd_ready), 0);
    @(negedge clk); hw_rst = 1'b0;
  endtask

  task automatic power_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit e, p;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: shipped state
    check("R1 ready", int'(cmd_ready), 1);
    check("R1 lockdown", int'(lockdown), 0);
    check("R1 std", int'(std_locked), 0);
    check("R1 pwd", int'(pwd_locked), 0);
    for (int b = 0; b < 32; b++) begin prot_of(b, p); check("R1 unprotected", int'(p), 0); end

    // R2: write-protect pin on edge blocks only
    wp_active = 1'b1;
    prot_of(0, p);  check("R2 wp blk0", int'(p), 1);
    prot_of(1, p);  check("R2 wp blk1", int'(p), 1);
    prot_of(2, p);  check("R2 wp blk2", int'(p), 0);
    prot_of(29, p); check("R2 wp blk29", int'(p), 0);
    prot_of(31, p); check("R2 wp blk31", int'(p), 1);
    wp_active = 1'b0;
    prot_of(31, p); check("R2 wp off", int'(p), 0);

    // R3 and R9: set a group bit, busy window
    send(5, 3, 0, 0, e); check("R3 set grp ok", int'(e), 0);
    busy_len(n); check("R9 busy length", n, PGM);
    prot_of(6, p); check("R3 blk6 prot", int'(p), 1);
    prot_of(7, p); check("R3 blk7 prot", int'(p), 1);
    prot_of(8, p); check("R3 blk8 clear", int'(p), 0);
    send(6, 0, 0, 0, e); check("R3 clear ok", int'(e), 0);
    busy_len(n);
    prot_of(6, p); check("R3 blk6 cleared", int'(p), 0);

    // R4: lock-down freezes group bits
    send(5, 3, 0, 0, e); busy_len(n);
    send(4, 0, 0, 0, e); check("R4 lock ok", int'(e), 0);
    busy_len(n); check("R9 no busy after lock", n, 0);
    check("R4 lockdown set", int'(lockdown), 1);
    send(6, 0, 0, 0, e); check("R3 clear rejected", int'(e), 1);
    prot_of(6, p); check("R3 blk6 still prot", int'(p), 1);
    send(5, 5, 0, 0, e); check("R3 set rejected", int'(e), 1);
    prot_of(10, p); check("R3 blk10 untouched", int'(p), 0);

    // R5, R7, R10 rejections in standard mode
    send(1, 0, 0, 0, e); check("R5 pwd mode needs password", int'(e), 1);
    check("R5 pwd not set", int'(pwd_locked), 0);
    send(3, 0, 0, 16'hFFFF, e); check("R7 verify outside pwd mode", int'(e), 1);
    send(7, 0, 0, 0, e); check("R10 invalid op", int'(e), 1);
    check("R10 no lockdown change", int'(lockdown), 1);

    // R4: hardware reset clears lock-down in standard mode, keeps group bits
    pulse_hw();
    check("R4 hw reset clears", int'(lockdown), 0);
    prot_of(6, p); check("R3 grp survives hw reset", int'(p), 1);

    // R6: program password
    send(2, 0, 0, 16'h1234, e); check("R6 pgm w0", int'(e), 0); busy_len(n);
    send(2, 0, 1, 16'h5678, e); busy_len(n);
    send(2, 0, 2, 16'h9ABC, e); busy_len(n);
    send(2, 0, 3, 16'hDEF0, e); check("R6 pgm w3", int'(e), 0); busy_len(n);

    // R5: enter password mode
    send(1, 0, 0, 0, e); check("R5 pwd mode ok", int'(e), 0); busy_len(n);
    check("R5 pwd locked", int'(pwd_locked), 1);
    check("R5 lockdown on entry", int'(lockdown), 1);
    send(0, 0, 0, 0, e); check("R5 std after pwd", int'(e), 1);
    check("R5 std stays clear", int'(std_locked), 0);
    send(2, 0, 0, 16'h0000, e); check("R6 pgm after pwd mode", int'(e), 1);

    // R7: wrong password
    send(3, 0, 0, 16'h1234, e); check("R7 step0 no err", int'(e), 0);
    send(3, 0, 1, 16'h5678, e);
    send(3, 0, 2, 16'h0BAD, e); check("R7 mismatch hidden", int'(e), 0);
    send(3, 0, 3, 16'hDEF0, e); check("R7 wrong pw err", int'(e), 1);
    check("R7 lockdown kept", int'(lockdown), 1);
    // R7: out of order
    send(3, 0, 0, 16'h1234, e);
    send(3, 0, 2, 16'h9ABC, e); check("R7 out of order", int'(e), 1);
    // R7: correct password
    send(3, 0, 0, 16'h1234, e);
    send(3, 0, 1, 16'h5678, e);
    send(3, 0, 2, 16'h9ABC, e);
    send(3, 0, 3, 16'hDEF0, e); check("R7 right pw", int'(e), 0);
    check("R7 lockdown cleared", int'(lockdown), 0);
    send(6, 0, 0, 0, e); check("R3 clear after unlock", int'(e), 0); busy_len(n);
    prot_of(6, p); check("R3 blk6 cleared", int'(p), 0);
    // R7: interrupted sequence
    send(3, 0, 0, 16'h1234, e);
    send(3, 0, 1, 16'h5678, e);
    send(5, 1, 0, 0, e); busy_len(n);
    send(3, 0, 2, 16'h9ABC, e); check("R7 interrupted", int'(e), 1);

    // R4: hardware reset in password mode sets lock-down
    pulse_hw();
    check("R4 hw reset in pwd mode", int'(lockdown), 1);

    // R5: standard mode blocks password mode
    power_reset();
    @(negedge clk);
    check("R1 power reset lockdown", int'(lockdown), 0);
    send(0, 0, 0, 0, e); check("R5 std ok", int'(e), 0); busy_len(n);
    check("R5 std set", int'(std_locked), 1);
    for (int w = 0; w < 4; w++) begin send(2, 0, w, w, e); busy_len(n); end
    send(1, 0, 0, 0, e); check("R5 pwd after std", int'(e), 1);
    check("R5 pwd clear", int'(pwd_locked), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule